// File: doc/BRIEF.md
# Host Interrupt Generation Register

This block is a 32-bit memory-mapped register through which software raises an interrupt toward an external host and records which sources asked for it. The upper 28 bits are sticky source flags. Bit 0 is a trigger: writing it with 1 fires one shaped pulse on a single registered output pin. A companion write-one-to-clear register shares the same flag storage and is how software or the host acknowledges sources.

The pulse is high for 4 ticks and then low for 4 ticks. A tick is one cycle of the slow configuration clock. When the block runs on a fast clock, a tick is one enable from a divide-by-`DIV_RATIO` counter, and that counter restarts when a pulse is accepted. The whole 8-tick frame is a lockout window. A trigger that arrives inside it is dropped and leaves nothing pending.

There are two write strobes, one per register, and they share one data bus. Both registers read back through the same read port, because they expose the same flags. There is no flow control on this register interface: every strobe takes effect in the cycle it is sampled.

Top module: `host_irq_gen`

## Requirements
- R1: While reset is held, and right after it is released, `rd_data` reads 0 and `host_irq` is low.
- R2: A write on `wr_gen` sets every flag in `rd_data[31:4]` whose `wr_data` bit is 1. Flags whose data bit is 0 keep their value.
- R3: A write on `wr_clr` clears every flag in `rd_data[31:4]` whose `wr_data` bit is 1. Flags whose data bit is 0 keep their value.
- R4: When `wr_gen` and `wr_clr` are both high in one cycle, every flag whose data bit is 1 ends up set. The set wins over the clear.
- R5: `rd_data[3:0]` always reads 0. Writing ones to bits 3..1 through either strobe changes no flag and starts no pulse.
- R6: A `wr_gen` write with `wr_data[0]`=1, sampled at edge k while no frame is active, drives `host_irq` high after edges k through k+4·DIV_RATIO−1. After edge k+4·DIV_RATIO it is low.
- R7: A trigger sampled at edges k+1 through k+8·DIV_RATIO is dropped: no pulse starts and none is left pending. A trigger at edge k+8·DIV_RATIO+1 starts a new pulse.
- R8: A `wr_gen` write with `wr_data[0]`=0 starts no pulse. A `wr_clr` write starts no pulse, whatever the value of bit 0.
- R9: One `wr_gen` write can both set flags and fire a pulse. The flag update does not depend on whether the trigger was accepted or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (slow clock, or fast clock paced by the divider) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_gen | input | 1 | Write strobe for the generation register |
| wr_clr | input | 1 | Write strobe for the write-one-to-clear register |
| wr_data | input | 32 | Write data shared by both strobes |
| rd_data | output | 32 | Read value of either register: flags in 31..4, zeros in 3..0 |
| host_irq | output | 1 | Registered, stretched interrupt pulse toward the host |

## Verification
Flag patterns are applied with alternating and sparse bit groups, written through the set strobe, the clear strobe and both strobes at once. These patterns distinguish accumulation from overwrite, and show which strobe takes priority. Triggers are issued from idle, in the middle of a frame, at the last locked edge and at the first free edge. This measures the pulse shape exactly and places the lockout boundary to one cycle. Triggers carried by clear writes or with bit 0 at zero, and writes to the reserved bits, confirm that none of them produces a pulse or a flag change.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int REG_W       = 32;
  localparam int FLAG_LSB    = 4;
  localparam int FLAG_W      = REG_W - FLAG_LSB;
  localparam int HIGH_TICKS  = 4;
  localparam int FRAME_TICKS = 8;
  localparam int PHASE_W     = $clog2(FRAME_TICKS);

  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/host_irq_tick.sv
module host_irq_tick #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      logic unused_tick_in;
      assign unused_tick_in = restart ^ clk ^ rst_n;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      // R6
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/host_irq_flags.sv
module host_irq_flags
  import host_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_we,
  input  logic      clr_we,
  input  flag_vec_t data,
  output flag_vec_t flags_o
);
  flag_vec_t flags_q;
  flag_vec_t set_mask;
  flag_vec_t clr_mask;

  always_comb begin
    set_mask = set_we ? data : '0;
    clr_mask = clr_we ? data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | set_mask;
  end

  assign flags_o = flags_q;

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((flags_o & $past(data)) == $past(data)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((flags_o & $past(data)) == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(flags_o));
endmodule

// File: rtl/host_irq_pulse.sv
module host_irq_pulse
  import host_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  output logic accept_o,
  output logic irq_o
);
  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(FRAME_TICKS - 1);
  localparam logic [PHASE_W-1:0] FALL_PH = PHASE_W'(HIGH_TICKS - 1);

  logic               active_q;
  logic [PHASE_W-1:0] phase_q;
  logic               irq_q;

  assign accept_o = trig && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      irq_q    <= 1'b0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      phase_q  <= '0;
      irq_q    <= 1'b1;
    end else if (active_q && tick) begin
      if (phase_q == LAST_PH) begin
        active_q <= 1'b0;
        phase_q  <= '0;
      end else begin
        phase_q  <= phase_q + 1'b1;
      end
      if (phase_q >= FALL_PH) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  // R7
  locked_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && active_q) |=> !$rose(irq_o));

  // R6
  rise_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(trig));

  // R6
  high_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> active_q);

  // R7
  locked_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && active_q && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/host_irq_gen.sv
module host_irq_gen
  import host_irq_pkg::*;
#(
  parameter int DIV_RATIO = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_gen,
  input  logic             wr_clr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             host_irq
);
  flag_vec_t flags;
  logic      tick;
  logic      accept;
  logic      trig;
  logic      unused_rsvd;

  assign unused_rsvd = ^wr_data[FLAG_LSB-1:1];
  assign trig        = wr_gen && wr_data[0];

  host_irq_tick #(.DIV(DIV_RATIO)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick_o  (tick)
  );

  host_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (wr_gen),
    .clr_we  (wr_clr),
    .data    (wr_data[REG_W-1:FLAG_LSB]),
    .flags_o (flags)
  );

  host_irq_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .trig     (trig),
    .accept_o (accept),
    .irq_o    (host_irq)
  );

  assign rd_data = {flags, {FLAG_LSB{1'b0}}};

  // R8
  clr_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_gen && !host_irq) |=> !host_irq);
endmodule

// File: tb/host_irq_gen_bench.sv
`timescale 1ns/100ps
module host_irq_gen_bench;
  localparam int D = 6;

  typedef struct {
    logic        irq;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_gen = 1'b0;
  logic        wr_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        host_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  exp_t q[$];

  logic [27:0] m_src = '0;
  bit          m_act = 0;
  int          m_cnt = 0;
  logic        m_irq = 0;

  host_irq_gen #(.DIV_RATIO(D)) u_host_irq_gen (
    .clk(clk), .rst_n(rst_n), .wr_gen(wr_gen), .wr_clr(wr_clr),
    .wr_data(wr_data), .rd_data(rd_data), .host_irq(host_irq)
  );

  always #2.5 clk = ~clk;

  task automatic step(input bit rst_v, input bit g, input bit c,
                      input logic [31:0] d, input string tag);
    exp_t e;
    bit acc;
    @(negedge clk);
    #1;
    rst_n = rst_v; wr_gen = g; wr_clr = c; wr_data = d;
    if (!rst_v) begin
      m_src = '0; m_act = 0; m_cnt = 0; m_irq = 0;
    end else begin
      acc = g && d[0] && !m_act;
      if (c) m_src = m_src & ~d[31:4];
      if (g) m_src = m_src | d[31:4];
      if (acc) begin
        m_act = 1; m_cnt = 0; m_irq = 1;
      end else if (m_act) begin
        m_cnt++;
        m_irq = (m_cnt < 4*D);
        if (m_cnt == 8*D) m_act = 0;
      end
    end
    e.irq = m_irq; e.rd = {m_src, 4'b0000}; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 32'h0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (host_irq !== e.irq) begin
          failures++;
          $display("FAIL %s host_irq actual=%b expected=%b", e.tag, host_irq, e.irq);
        end
        checks++;
        if (rd_data !== e.rd) begin
          failures++;
          $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) step(0, 0, 0, 32'h0, "R1 reset");
    idle(3, "R1 after reset");
    // R2: alternating pattern, then accumulate a sparse group
    step(1, 1, 0, 32'hA5A5_A5A0, "R2 set pattern");
    step(1, 1, 0, 32'h0000_00F0, "R2 accumulate");
    step(1, 1, 0, 32'h0000_0000, "R2 zero write");
    idle(2, "R2 hold");
    // R5: reserved bits through both strobes
    step(1, 1, 0, 32'h0000_000E, "R5 reserved via set");
    step(1, 0, 1, 32'h0000_000E, "R5 reserved via clear");
    idle(2, "R5 hold");
    // R3
    step(1, 0, 1, 32'hA000_0000, "R3 clear group");
    step(1, 0, 1, 32'h0000_0000, "R3 clear zero");
    step(1, 0, 1, 32'h0F0F_0F00, "R3 clear mixed");
    // R4
    step(1, 1, 1, 32'h5000_0010, "R4 set wins");
    step(1, 1, 1, 32'h0500_0000, "R4 set wins again");
    idle(2, "R4 hold");
    // R8: no pulse from clear or bit0=0
    step(1, 0, 1, 32'h0000_0001, "R8 clear with bit0");
    idle(3, "R8 after clear");
    step(1, 1, 0, 32'h0000_0020, "R8 set with bit0 zero");
    idle(3, "R8 after set");
    // R6: pulse from idle
    step(1, 1, 0, 32'h0000_0001, "R6 trigger");
    idle(8*D + 4, "R6 pulse shape");
    // R7: mid-window drop, no pending
    step(1, 1, 0, 32'h0000_0001, "R7 first trigger");
    idle(9, "R7 frame");
    step(1, 1, 0, 32'h0000_0001, "R7 mid drop");
    idle(8*D + 6, "R7 no pending");
    // R7: boundary
    step(1, 1, 0, 32'h0000_0001, "R7 boundary start");
    idle(8*D - 1, "R7 boundary frame");
    step(1, 1, 0, 32'h0000_0001, "R7 last locked edge");
    step(1, 1, 0, 32'h0000_0001, "R7 first free edge");
    idle(8*D + 2, "R7 second pulse");
    // R9: flags plus pulse, and flags on dropped trigger
    step(1, 1, 0, 32'h8000_0001, "R9 flag and pulse");
    idle(5, "R9 frame");
    step(1, 1, 0, 32'h0100_0001, "R9 flag on dropped trigger");
    idle(8*D, "R9 tail");
    idle(2, "drain");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule